// File: doc/BRIEF.md
# Context-Banked Register File with Address Translation

This block holds a general-purpose register file that several hardware threads (contexts) share. It translates each register specifier taken from an instruction into a physical index in that file. Every specifier carries its own mode bit. In absolute mode the 7-bit register field is used directly as the physical index. In context-relative mode the number of the running context is joined above the low bits of the register field. Each context then works in its own equal region of the file, and one code image can run on every context while each context keeps separate data.

A configuration bit selects the region layout. With eight regions each context owns 16 registers. With four regions the pairs of contexts (0,1), (2,3), (4,5) and (6,7) each own 32 registers, and the low context bit plays no part. The block serves two combinational read ports, A and B, and one synchronous write port. Each port translates its specifier on its own, so the three ports can use different modes in the same cycle. The translated read indices are brought out so that the decode stage can observe them.

Top module: `ctx_bank_regfile`

## Requirements
- R1: After reset every register reads as zero, and the layout is eight regions (`fourRegion` = 0).
- R2: A cycle with `cfgWrEn` = 1 loads `cfgFourRegion` into the layout bit (1 = four regions, 0 = eight regions), and the new layout applies from the next cycle. While `cfgWrEn` = 0 the layout keeps its value whatever `cfgFourRegion` does.
- R3: In eight-region layout, a relative specifier maps to index `ctx*16 + reg[3:0]`, and bits 6:4 of the register field are ignored. For example, context 2, register 0 maps to 32.
- R4: In four-region layout, a relative specifier maps to index `ctx[2:1]*32 + reg[4:0]`. Context bit 0 and register bits 6:5 are ignored, so context 3, register 31 maps to 63 and context 6, register 0 maps to 96.
- R5: An absolute specifier (mode bit = 1) maps to index `reg[6:0]` in either layout and for any context.
- R6: Read port A, read port B and the write port each apply their own mode bit. Mixed modes in one cycle each resolve according to R3 to R5.
- R7: When `wrEn` = 1 at a rising clock edge, `wrData` is stored at the translated write index. When `wrEn` = 0 no register changes.
- R8: `rdAData` and `rdBData` show, in the same cycle and without a clock, the contents at `rdAIdx` and `rdBIdx`.
- R9: A read and a write to the same physical index in one cycle return the old contents. The new value is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Load strobe for the layout bit |
| cfgFourRegion | input | 1 | Layout value to load: 1 = four regions, 0 = eight |
| ctxNum | input | 3 | Number of the running context |
| rdAReg | input | 7 | Register field for read port A |
| rdAAbs | input | 1 | Port A mode: 1 = absolute, 0 = relative |
| rdBReg | input | 7 | Register field for read port B |
| rdBAbs | input | 1 | Port B mode: 1 = absolute, 0 = relative |
| wrEn | input | 1 | Write enable |
| wrReg | input | 7 | Register field for the write port |
| wrAbs | input | 1 | Write port mode: 1 = absolute, 0 = relative |
| wrData | input | 32 | Data to write |
| rdAData | output | 32 | Read data, port A |
| rdBData | output | 32 | Read data, port B |
| rdAIdx | output | 7 | Translated physical index, port A |
| rdBIdx | output | 7 | Translated physical index, port B |
| fourRegion | output | 1 | Current layout bit |

## Verification
Two functions can fall in the same cycle.

The first pair is a write and a read that resolve to the same physical index. The bench provokes this with a relative write and an absolute read that meet at the same index. It judges the result by the old value on the read port in that cycle and by the new value in the following cycle. The case is checked in both layouts.

The second pair is a layout change and a translation in the same cycle. The bench issues `cfgWrEn` together with relative reads and a relative write. It expects the old layout to govern that cycle, including the index the write lands on, and the new layout to govern from the next cycle. A reference model in the bench queues the expected indices and data, and a monitor compares them.

// File: rtl/ctx_bank_pkg.sv
`timescale 1ns/1ps
package ctx_bank_pkg;
  localparam int REG_COUNT = 128;
  localparam int DATA_W    = 32;
  localparam int CTX_W     = 3;
  localparam int IDX_W     = $clog2(REG_COUNT);
  localparam int LO8_W     = IDX_W - CTX_W;   // register bits used with eight regions
  localparam int LO4_W     = LO8_W + 1;       // register bits used with four regions

  typedef struct packed {
    logic             wrStrobe;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdAIdx;
    logic [IDX_W-1:0] rdBIdx;
  } bankStrobe_t;
endpackage

// File: rtl/ctx_bank_ctrl.sv
`timescale 1ns/1ps
module ctx_bank_ctrl
  import ctx_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic                cfgFourRegion,
  input  logic [CTX_W-1:0]    ctxNum,
  input  logic [IDX_W-1:0]    rdAReg,
  input  logic                rdAAbs,
  input  logic [IDX_W-1:0]    rdBReg,
  input  logic                rdBAbs,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrReg,
  input  logic                wrAbs,
  output logic                fourMode,
  output bankStrobe_t         strobe
);
  localparam int PORTS = 3;

  // layout register, resets to eight regions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        fourMode <= 1'b0;
    else if (cfgWrEn) fourMode <= cfgFourRegion;
  end

  logic [IDX_W-1:0] specReg [PORTS];
  logic             specAbs [PORTS];
  logic [IDX_W-1:0] physIdx [PORTS];

  assign specReg[0] = rdAReg;  assign specAbs[0] = rdAAbs;
  assign specReg[1] = rdBReg;  assign specAbs[1] = rdBAbs;
  assign specReg[2] = wrReg;   assign specAbs[2] = wrAbs;

  genvar p;
  generate
    for (p = 0; p < PORTS; p++) begin : g_xlate
      always_comb begin
        if (specAbs[p])
          physIdx[p] = specReg[p];
        else if (fourMode)
          physIdx[p] = {ctxNum[CTX_W-1:1], specReg[p][LO4_W-1:0]};
        else
          physIdx[p] = {ctxNum, specReg[p][LO8_W-1:0]};
      end
    end
  endgenerate

  assign strobe.rdAIdx   = physIdx[0];
  assign strobe.rdBIdx   = physIdx[1];
  assign strobe.wrIdx    = physIdx[2];
  assign strobe.wrStrobe = wrEn;

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(fourMode));
  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> fourMode == $past(cfgFourRegion));
  assert_rel_eight_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!fourMode && !rdAAbs) |-> (strobe.rdAIdx[IDX_W-1:LO8_W] == ctxNum));
  assert_rel_four_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fourMode && !rdBAbs) |-> (strobe.rdBIdx[IDX_W-1:LO4_W] == ctxNum[CTX_W-1:1]));
  assert_abs_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrAbs |-> (strobe.wrIdx == wrReg));
endmodule

// File: rtl/ctx_bank_dp.sv
`timescale 1ns/1ps
module ctx_bank_dp
  import ctx_bank_pkg::*;
#(
  parameter int WIDTH = DATA_W
)(
  input  logic             clk,
  input  logic             rstN,
  input  bankStrobe_t      strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdAData,
  output logic [WIDTH-1:0] rdBData
);
  logic [WIDTH-1:0] regMem [REG_COUNT];

  genvar i;
  generate
    for (i = 0; i < REG_COUNT; i++) begin : g_entry
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          regMem[i] <= '0;
        else if (strobe.wrStrobe && (strobe.wrIdx == IDX_W'(i)))
          regMem[i] <= wrData;
      end
    end
  endgenerate

  // combinational reads see pre-edge contents: read-before-write
  assign rdAData = regMem[strobe.rdAIdx];
  assign rdBData = regMem[strobe.rdBIdx];

  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrStrobe |=> regMem[$past(strobe.wrIdx)] == $past(wrData));
  assert_old_on_clash_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStrobe && strobe.rdAIdx == strobe.wrIdx) |=>
      regMem[$past(strobe.wrIdx)] == $past(wrData));
endmodule

// File: rtl/ctx_bank_regfile.sv
`timescale 1ns/1ps
module ctx_bank_regfile
  import ctx_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgFourRegion,
  input  logic [CTX_W-1:0]  ctxNum,
  input  logic [IDX_W-1:0]  rdAReg,
  input  logic              rdAAbs,
  input  logic [IDX_W-1:0]  rdBReg,
  input  logic              rdBAbs,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrReg,
  input  logic              wrAbs,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdAData,
  output logic [DATA_W-1:0] rdBData,
  output logic [IDX_W-1:0]  rdAIdx,
  output logic [IDX_W-1:0]  rdBIdx,
  output logic              fourRegion
);
  bankStrobe_t strobe;

  ctx_bank_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgFourRegion(cfgFourRegion),
    .ctxNum(ctxNum), .rdAReg(rdAReg), .rdAAbs(rdAAbs), .rdBReg(rdBReg),
    .rdBAbs(rdBAbs), .wrEn(wrEn), .wrReg(wrReg), .wrAbs(wrAbs),
    .fourMode(fourRegion), .strobe(strobe)
  );

  ctx_bank_dp #(.WIDTH(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdAData(rdAData), .rdBData(rdBData)
  );

  assign rdAIdx = strobe.rdAIdx;
  assign rdBIdx = strobe.rdBIdx;
endmodule

// File: tb/test_ctx_bank_regfile.sv
`timescale 1ns/1ps
module test_ctx_bank_regfile;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, cfgWrEn, cfgFourRegion, rdAAbs, rdBAbs, wrEn, wrAbs, fourRegion;
  logic [2:0] ctxNum;
  logic [6:0] rdAReg, rdBReg, wrReg, rdAIdx, rdBIdx;
  logic [31:0] wrData, rdAData, rdBData;

  ctx_bank_regfile i_ctx_bank_regfile (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgFourRegion(cfgFourRegion),
    .ctxNum(ctxNum), .rdAReg(rdAReg), .rdAAbs(rdAAbs), .rdBReg(rdBReg),
    .rdBAbs(rdBAbs), .wrEn(wrEn), .wrReg(wrReg), .wrAbs(wrAbs), .wrData(wrData),
    .rdAData(rdAData), .rdBData(rdBData), .rdAIdx(rdAIdx), .rdBIdx(rdBIdx),
    .fourRegion(fourRegion)
  );

  typedef struct {
    string       req;
    logic        four;
    logic [6:0]  idxA, idxB;
    logic [31:0] dA, dB;
  } exp_t;

  exp_t q[$];
  event monEv;
  int tests = 0, fails = 0;
  logic [31:0] mMem [128];
  logic mFour;

  // reference mapping written from R3, R4 and R5
  function automatic logic [6:0] xl(logic four, logic [2:0] c, logic [6:0] r, logic ab);
    if (ab)   return r;
    if (four) return 7'(c[2:1] * 32 + r[4:0]);
    return 7'(c * 16 + r[3:0]);
  endfunction

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected items and compares them with the outputs
  initial forever begin
    exp_t e;
    @(monEv);
    #1;
    e = q.pop_front();
    cmp(e.req, "fourRegion", 32'(fourRegion), 32'(e.four));
    cmp(e.req, "rdAIdx", 32'(rdAIdx), 32'(e.idxA));
    cmp(e.req, "rdBIdx", 32'(rdBIdx), 32'(e.idxB));
    cmp(e.req, "rdAData", rdAData, e.dA);
    cmp(e.req, "rdBData", rdBData, e.dB);
  end

  // driver: pushes expectations for this cycle, then steps the model at the edge
  task automatic cycle(string req);
    exp_t e;
    logic [6:0] wi;
    e.req  = req;
    e.four = mFour;
    e.idxA = xl(mFour, ctxNum, rdAReg, rdAAbs);
    e.idxB = xl(mFour, ctxNum, rdBReg, rdBAbs);
    e.dA   = mMem[e.idxA];
    e.dB   = mMem[e.idxB];
    q.push_back(e);
    -> monEv;
    wi = xl(mFour, ctxNum, wrReg, wrAbs);
    @(posedge clk);
    if (wrEn)    mMem[wi] = wrData;
    if (cfgWrEn) mFour = cfgFourRegion;
    @(negedge clk);
    cfgWrEn = 1'b0;
    wrEn    = 1'b0;
  endtask

  task automatic setRd(logic [2:0] c, logic [6:0] a, logic aAbs, logic [6:0] b, logic bAbs);
    ctxNum = c; rdAReg = a; rdAAbs = aAbs; rdBReg = b; rdBAbs = bAbs;
  endtask

  task automatic setWr(logic [6:0] r, logic ab, logic [31:0] d);
    wrEn = 1'b1; wrReg = r; wrAbs = ab; wrData = d;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgFourRegion = 1'b0; wrEn = 1'b0;
    wrReg = '0; wrAbs = 1'b0; wrData = '0;
    setRd(3'd0, 7'd0, 1'b1, 7'd0, 1'b1);
    for (int k = 0; k < 128; k++) mMem[k] = '0;
    mFour = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset contents and layout
    for (int k = 0; k < 128; k += 37) begin
      setRd(3'd0, 7'(k), 1'b1, 7'(127 - k), 1'b1);
      cycle("R1");
    end

    // R3: context 2 register 0 gives 32; upper register bits ignored
    setRd(3'd2, 7'd0, 1'b0, 7'h75, 1'b0);
    cycle("R3");

    // R7: relative writes from every context, eight regions
    for (int c = 0; c < 8; c++) begin
      setRd(3'(c), 7'd5, 1'b0, 7'd0, 1'b1);
      setWr(7'h05, 1'b0, 32'hA000_0000 + 32'(c));
      cycle("R7");
    end
    // R8: read back through absolute and relative ports
    for (int c = 0; c < 8; c++) begin
      setRd(3'(c), 7'h65, 1'b0, 7'(c * 16 + 5), 1'b1);
      cycle("R8");
    end

    // R7: wrEn low changes nothing
    setRd(3'd1, 7'd21, 1'b1, 7'd21, 1'b1);
    wrReg = 7'd21; wrAbs = 1'b1; wrData = 32'hDEAD_BEEF;
    cycle("R7");
    cycle("R7");

    // R2: cfgFourRegion toggling without strobe is ignored
    cfgFourRegion = 1'b1;
    cycle("R2");
    cycle("R2");

    // R2 and R9: layout change together with a relative write; old layout this cycle
    setRd(3'd3, 7'h03, 1'b0, 7'd51, 1'b1);
    cfgWrEn = 1'b1; cfgFourRegion = 1'b1;
    setWr(7'h03, 1'b0, 32'h1111_2222);
    cycle("R9");
    setRd(3'd3, 7'd51, 1'b1, 7'h03, 1'b0);
    cycle("R2");

    // R4: four-region mapping, context bit 0 and register bits 6:5 ignored
    setRd(3'd3, 7'h1F, 1'b0, 7'h60, 1'b0);
    cycle("R4");
    setRd(3'd6, 7'h00, 1'b0, 7'h7F, 1'b0);
    cycle("R4");
    setRd(3'd7, 7'h45, 1'b0, 7'h05, 1'b0);
    cycle("R4");

    // R5: absolute in four-region layout
    setRd(3'd6, 7'd5, 1'b1, 7'd117, 1'b1);
    cycle("R5");

    // R6 and R9: mixed modes, write relative clashing with absolute read A
    setRd(3'd5, 7'd80, 1'b1, 7'h10, 1'b0);
    setWr(7'h10, 1'b0, 32'h5A5A_0101);
    cycle("R9");
    setRd(3'd5, 7'd80, 1'b1, 7'h10, 1'b0);
    cycle("R9");

    // R6: write absolute while reads are relative
    setRd(3'd0, 7'h1E, 1'b0, 7'h01, 1'b0);
    setWr(7'd30, 1'b1, 32'h0BAD_F00D);
    cycle("R6");
    cycle("R6");

    // R2: back to eight regions
    cfgWrEn = 1'b1; cfgFourRegion = 1'b0;
    cycle("R2");
    setRd(3'd7, 7'd5, 1'b0, 7'd2, 1'b0);
    cycle("R3");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule